// File: doc/BRIEF.md
# Dual-Channel Power Switch Turn-On Sequencer

This block decides when each of two power-path switches may be driven on. It qualifies each channel's supply window and enable, debounces it for a long interval and keeps a per-channel turn-on control bit. That bit is loaded from the channel's ON input when the channel becomes ready, and afterwards a host write or a later ON rising edge can change it. A strap input selects one of two schemes. In paired mode both switches close in one cycle, and only once both channels are ready and both control bits are set. In independent mode each channel runs alone, but both share one start-up timer.

A power-on reset window runs after all supply-good flags are true. While it runs, the block holds every switch off and clears the control bits, the fault flags and the timer. In independent mode a host-triggered turn-on that arrives while the shared timer is busy is held back until the timer finishes, so each such channel gets a full start-up interval. A turn-on that an ON input causes skips that wait.

Top module: `dual_switch_seq`

## Requirements
- R1: `por_o` is high until `supply_ok_i` (both bits) and `core_ok_i` have been high together for POR_CYC consecutive cycles. Any drop of these flags restarts the window. While `por_o` is high, `gate_o`, `busy_o`, `ctrl_on_o` and `fault_o` are all zero.
- R2: For channel n, `status_o[4n+3:4n]` is {gate, ready, ov_ok, uv_ok}. Bit 0 is `uv_ok_i[n]` and bit 1 is `ov_ok_i[n]`, both taken straight from the inputs. Bit 2 is the debounced ready flag and bit 3 equals `gate_o[n]`.
- R3: A channel becomes ready only after DEB_CYC consecutive cycles with the reset window over, uv_ok and ov_ok high, and `en_ni` low. If any of these is lost, the count restarts from zero.
- R4: In the cycle a channel becomes ready, its `on_i` level is copied into its control bit (`ctrl_on_o[n]`). If the copied level is 1 and the channel may turn on, `gate_o[n]` rises one cycle later.
- R5: A ready channel whose control bit is 0 gets the bit set by a rising edge of `on_i[n]` or by a host write of 1. The gate then follows under R7 to R10.
- R6: A host write is a one-cycle `wr_i` strobe. `wr_sel_i` selects the channel and `wr_on_i` is the new control bit value. Writing 0 clears the bit, and that channel's gate falls one cycle after the write.
- R7: With `indep_i` low, both gates rise and fall in the same cycle. They are on only while both channels are ready and both control bits are set.
- R8: With `indep_i` high, a turn-on that starts while the timer is idle makes `busy_o` high for exactly SU_CYC cycles. A host-triggered turn-on that arrives while `busy_o` is high waits until `busy_o` falls, then turns on one cycle later and starts a new timer interval.
- R9: When both channels wait for an idle timer in the same cycle, channel 0 turns on and takes the timer. Channel 1 waits for the next interval.
- R10: A turn-on whose control bit was last set from `on_i` (at ready or by a rising edge) does not wait for the timer. Its gate rises one cycle after the request even when `busy_o` is high.
- R11: If any precondition of R3 drops while a gate is on, that gate falls in the next cycle and the channel leaves the ready state. The channel's `fault_o` bit is also set, and it stays set until the next reset window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 2 | Per-channel external supply above lockout |
| core_ok_i | input | 1 | Internal supply good |
| uv_ok_i | input | 2 | Per-channel input above undervoltage level |
| ov_ok_i | input | 2 | Per-channel input below overvoltage level |
| en_ni | input | 2 | Per-channel enable, active low |
| on_i | input | 2 | Per-channel turn-on request input |
| indep_i | input | 1 | 1 = independent channels, 0 = paired turn-on |
| wr_i | input | 1 | One-cycle host write strobe |
| wr_sel_i | input | 1 | Channel addressed by the write |
| wr_on_i | input | 1 | Value written to the control bit |
| gate_o | output | 2 | Per-channel switch gate enable |
| busy_o | output | 1 | Shared start-up timer running |
| por_o | output | 1 | Power-on reset window active |
| ctrl_on_o | output | 2 | Per-channel turn-on control bit |
| fault_o | output | 2 | Per-channel sticky loss-while-on fault |
| status_o | output | 8 | Per-channel status nibbles, channel 0 low |

## Verification
The assertions rely on all inputs being synchronous to `clk_i`. They also rely on `indep_i` being a strap: it changes only while both gates are off and the timer is idle, so the paired-gate equality and the timer-wait properties never straddle a mode switch. The stimulus drives inputs one time unit after the rising edge. It changes `indep_i` only after clearing both control bits and letting `busy_o` fall. Every write lasts exactly one cycle. A behavioural model of the rules above is compared against all outputs on every cycle.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int NCH = 2;

  typedef struct packed {
    logic gate;
    logic ready;
    logic ov_ok;
    logic uv_ok;
  } ch_stat_t;
endpackage

// File: rtl/pseq_por.sv
module pseq_por #(
  parameter int POR_CYC = 11250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_ok_i,
  output logic done_o
);
  localparam int W = (POR_CYC > 1) ? $clog2(POR_CYC) : 1;

  logic [W-1:0] cnt_q;
  logic         done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!sup_ok_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == W'(POR_CYC - 1)) done_q <= 1'b1;
      else                          cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  p_restart_on_loss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_ok_i |=> !done_o);
  p_done_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && sup_ok_i |=> done_o);
endmodule

// File: rtl/pseq_chan.sv
module pseq_chan #(
  parameter int DEB_CYC = 12500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_done_i,
  input  logic uv_ok_i,
  input  logic ov_ok_i,
  input  logic en_ni,
  input  logic on_i,
  input  logic wr_hit_i,
  input  logic wr_on_i,
  input  logic gate_i,
  output logic cond_o,
  output logic ready_o,
  output logic ctrl_o,
  output logic pin_o,
  output logic fault_o
);
  localparam int W = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  logic [W-1:0] cnt_q;
  logic ready_q, ctrl_q, pin_q, onq_q, fault_q;
  logic cond, fire, on_rise;

  assign cond    = por_done_i & uv_ok_i & ov_ok_i & ~en_ni;
  assign fire    = cond & ~ready_q & (cnt_q == W'(DEB_CYC - 1));
  assign on_rise = ready_q & on_i & ~onq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
      ctrl_q  <= 1'b0;
      pin_q   <= 1'b0;
      onq_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      onq_q <= on_i;
      if (!cond) begin
        cnt_q   <= '0;
        ready_q <= 1'b0;
      end else if (!ready_q) begin
        if (fire) ready_q <= 1'b1;
        else      cnt_q   <= cnt_q + 1'b1;
      end
      // priority: reset window, ready sample, host write, pin edge
      if (!por_done_i) begin
        ctrl_q <= 1'b0;
        pin_q  <= 1'b0;
      end else if (fire) begin
        ctrl_q <= on_i;
        pin_q  <= on_i;
      end else if (wr_hit_i) begin
        ctrl_q <= wr_on_i;
        pin_q  <= 1'b0;
      end else if (on_rise) begin
        ctrl_q <= 1'b1;
        pin_q  <= 1'b1;
      end
      if (!por_done_i)         fault_q <= 1'b0;
      else if (gate_i && !cond) fault_q <= 1'b1;
    end
  end

  assign cond_o  = cond;
  assign ready_o = ready_q;
  assign ctrl_o  = ctrl_q;
  assign pin_o   = pin_q;
  assign fault_o = fault_q;

  p_ready_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_o |=> !ready_o);
  p_sample_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ctrl_o == $past(on_i));
  p_host_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit_i && !wr_on_i && ready_o |=> !ctrl_o);
  p_fault_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i && !cond_o && por_done_i |=> fault_o);
endmodule

// File: rtl/pseq_arb.sv
module pseq_arb #(
  parameter int SU_CYC = 1250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       indep_i,
  input  logic       por_done_i,
  input  logic [1:0] cond_i,
  input  logic [1:0] ready_i,
  input  logic [1:0] ctrl_i,
  input  logic [1:0] pin_i,
  output logic [1:0] gate_o,
  output logic       busy_o
);
  localparam int W = (SU_CYC > 1) ? $clog2(SU_CYC) : 1;

  logic [W-1:0] tmr_q;
  logic         busy_q;
  logic [1:0]   gate_q, gate_nx, keep, want, turn_on;
  logic         free, take0, take1, start, pair_ok;

  assign keep  = cond_i & ready_i & ctrl_i;
  assign want  = keep & ~gate_q;
  assign free  = ~busy_q;
  assign take0 = want[0] & free;
  assign take1 = want[1] & free & ~take0;
  assign pair_ok = &keep;

  always_comb begin
    turn_on[0] = want[0] & (pin_i[0] | free);
    turn_on[1] = want[1] & (pin_i[1] | take1);
    if (indep_i) begin
      gate_nx = keep & (gate_q | turn_on);
      start   = take0 | take1;
    end else begin
      gate_nx = {2{pair_ok}};
      start   = pair_ok & ~gate_q[0] & free;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      gate_q <= gate_nx;
      if (!por_done_i) begin
        busy_q <= 1'b0;
        tmr_q  <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        tmr_q  <= '0;
      end else if (busy_q) begin
        if (tmr_q == W'(SU_CYC - 1)) busy_q <= 1'b0;
        else                         tmr_q  <= tmr_q + 1'b1;
      end
    end
  end

  assign gate_o = gate_q;
  assign busy_o = busy_q;

  p_off_in_por_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_done_i |=> gate_o == 2'b00 && !busy_o);
  p_paired_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !indep_i && $past(!indep_i) |-> gate_o[0] == gate_o[1]);
  p_loss_off0_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o[0] && !cond_i[0] |=> !gate_o[0]);
  p_loss_off1_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o[1] && !cond_i[1] |=> !gate_o[1]);
  p_wait0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[0]) && $past(indep_i) && $past(busy_o) |-> $past(pin_i[0]));
  p_wait1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[1]) && $past(indep_i) && $past(busy_o) |-> $past(pin_i[1]));
  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o[0]) && $past(!busy_o) && $past(por_done_i) |-> busy_o);
endmodule

// File: rtl/dual_switch_seq.sv
module dual_switch_seq
  import pseq_pkg::*;
#(
  parameter int POR_CYC = 11250,
  parameter int DEB_CYC = 12500000,
  parameter int SU_CYC  = 1250000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] supply_ok_i,
  input  logic       core_ok_i,
  input  logic [1:0] uv_ok_i,
  input  logic [1:0] ov_ok_i,
  input  logic [1:0] en_ni,
  input  logic [1:0] on_i,
  input  logic       indep_i,
  input  logic       wr_i,
  input  logic       wr_sel_i,
  input  logic       wr_on_i,
  output logic [1:0] gate_o,
  output logic       busy_o,
  output logic       por_o,
  output logic [1:0] ctrl_on_o,
  output logic [1:0] fault_o,
  output logic [7:0] status_o
);
  logic           por_done;
  logic [NCH-1:0] cond, ready, ctrl, pin, fault, wr_hit, gate;
  ch_stat_t       stat [NCH];

  pseq_por #(.POR_CYC(POR_CYC)) u_por (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sup_ok_i (&supply_ok_i & core_ok_i),
    .done_o   (por_done)
  );

  assign wr_hit = {wr_i & wr_sel_i, wr_i & ~wr_sel_i};

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pseq_chan #(.DEB_CYC(DEB_CYC)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .por_done_i (por_done),
      .uv_ok_i    (uv_ok_i[n]),
      .ov_ok_i    (ov_ok_i[n]),
      .en_ni      (en_ni[n]),
      .on_i       (on_i[n]),
      .wr_hit_i   (wr_hit[n]),
      .wr_on_i    (wr_on_i),
      .gate_i     (gate[n]),
      .cond_o     (cond[n]),
      .ready_o    (ready[n]),
      .ctrl_o     (ctrl[n]),
      .pin_o      (pin[n]),
      .fault_o    (fault[n])
    );
    assign stat[n] = '{gate: gate[n], ready: ready[n], ov_ok: ov_ok_i[n], uv_ok: uv_ok_i[n]};
    assign status_o[4*n +: 4] = stat[n];
  end

  pseq_arb #(.SU_CYC(SU_CYC)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .indep_i    (indep_i),
    .por_done_i (por_done),
    .cond_i     (cond),
    .ready_i    (ready),
    .ctrl_i     (ctrl),
    .pin_i      (pin),
    .gate_o     (gate),
    .busy_o     (busy_o)
  );

  assign gate_o    = gate;
  assign por_o     = ~por_done;
  assign ctrl_on_o = ctrl;
  assign fault_o   = fault;

  p_por_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_o |=> ctrl_on_o == 2'b00 && fault_o == 2'b00);
  p_status_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] == gate_o[0] && status_o[7] == gate_o[1]);
endmodule

// File: tb/sim_dual_switch_seq.sv
`timescale 1ns/1ps
module sim_dual_switch_seq;
  localparam int POR = 8;
  localparam int DEB = 10;
  localparam int SU  = 12;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] supply_ok_i = 2'b00;
  logic       core_ok_i = 1'b0;
  logic [1:0] uv_ok_i = 2'b00, ov_ok_i = 2'b00, en_ni = 2'b11, on_i = 2'b00;
  logic       indep_i = 1'b1;
  logic       wr_i = 1'b0, wr_sel_i = 1'b0, wr_on_i = 1'b0;
  logic [1:0] gate_o, ctrl_on_o, fault_o;
  logic       busy_o, por_o;
  logic [7:0] status_o;

  always #4 clk_i = ~clk_i;

  dual_switch_seq #(.POR_CYC(POR), .DEB_CYC(DEB), .SU_CYC(SU)) u0 (.*);

  int    errors = 0, checks = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // behavioural reference
  int m_good, m_run [2], m_left;
  bit m_pd, m_rdy [2], m_ctrl [2], m_pin [2], m_onq [2], m_gate [2], m_flt [2];
  bit c_ok [2], c_fire [2], c_keep [2], c_want [2], c_gn [2], c_take0, c_take1, c_start, c_idle, c_pair;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_good = 0; m_left = 0; m_pd = 0;
      for (int n = 0; n < 2; n++) begin
        m_run[n] = 0; m_rdy[n] = 0; m_ctrl[n] = 0; m_pin[n] = 0;
        m_onq[n] = 0; m_gate[n] = 0; m_flt[n] = 0;
      end
    end else begin
      for (int n = 0; n < 2; n++) begin
        c_ok[n]   = m_pd && uv_ok_i[n] && ov_ok_i[n] && !en_ni[n];
        c_fire[n] = c_ok[n] && !m_rdy[n] && (m_run[n] == DEB - 1);
        c_keep[n] = c_ok[n] && m_rdy[n] && m_ctrl[n];
        c_want[n] = c_keep[n] && !m_gate[n];
      end
      c_idle  = (m_left == 0);
      c_take0 = c_want[0] && c_idle;
      c_take1 = c_want[1] && c_idle && !c_take0;
      if (indep_i) begin
        c_gn[0] = c_keep[0] && (m_gate[0] || (c_want[0] && (m_pin[0] || c_idle)));
        c_gn[1] = c_keep[1] && (m_gate[1] || (c_want[1] && (m_pin[1] || c_take1)));
        c_start = c_take0 || c_take1;
      end else begin
        c_pair  = c_keep[0] && c_keep[1];
        c_gn[0] = c_pair; c_gn[1] = c_pair;
        c_start = c_pair && !m_gate[0] && c_idle;
      end
      if (!m_pd) m_left = 0;
      else if (c_start) m_left = SU;
      else if (m_left > 0) m_left--;
      for (int n = 0; n < 2; n++) begin
        if (!m_pd) begin m_ctrl[n] = 0; m_pin[n] = 0; m_flt[n] = 0; end
        else begin
          if (c_fire[n]) begin m_ctrl[n] = on_i[n]; m_pin[n] = on_i[n]; end
          else if (wr_i && wr_sel_i == 1'(n)) begin m_ctrl[n] = wr_on_i; m_pin[n] = 0; end
          else if (m_rdy[n] && on_i[n] && !m_onq[n]) begin m_ctrl[n] = 1; m_pin[n] = 1; end
          if (m_gate[n] && !c_ok[n]) m_flt[n] = 1;
        end
        m_onq[n] = on_i[n];
        if (!c_ok[n]) begin m_run[n] = 0; m_rdy[n] = 0; end
        else if (c_fire[n]) m_rdy[n] = 1;
        else if (!m_rdy[n]) m_run[n]++;
        m_gate[n] = c_gn[n];
      end
      if (!(&supply_ok_i && core_ok_i)) begin m_good = 0; m_pd = 0; end
      else if (!m_pd) begin
        if (m_good == POR - 1) m_pd = 1; else m_good++;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      logic [7:0] exp_st;
      logic [9:0] exp_v, act_v;
      exp_st = {m_gate[1], m_rdy[1], ov_ok_i[1], uv_ok_i[1], m_gate[0], m_rdy[0], ov_ok_i[0], uv_ok_i[0]};
      exp_v  = {m_gate[1], m_gate[0], m_left > 0, !m_pd, m_ctrl[1], m_ctrl[0], m_flt[1], m_flt[0], 2'b00};
      act_v  = {gate_o, busy_o, por_o, ctrl_on_o, fault_o, 2'b00};
      checks++;
      if (exp_v !== act_v || exp_st !== status_o) begin
        errors++;
        $display("FAIL %s model compare: actual gate/busy/por/ctrl/fault=%b status=%b expected %b status=%b",
                 cur_req, act_v, status_o, exp_v, exp_st);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input bit ch, input bit val);
    wr_i = 1'b1; wr_sel_i = ch; wr_on_i = val;
    step(1);
    wr_i = 1'b0;
  endtask

  task automatic report();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    cur_req = "R1";
    chk("R1 reset state", {gate_o, busy_o, por_o, fault_o, ctrl_on_o}, 8'b0001_0000);
    supply_ok_i = 2'b11; core_ok_i = 1'b1;
    step(4);
    chk("R1 window active", por_o, 1);
    step(8);
    chk("R1 window over", por_o, 0);

    // R4: ch0 ready with ON high, turns on and starts timer
    cur_req = "R4";
    uv_ok_i[0] = 1; ov_ok_i[0] = 1; en_ni[0] = 0; on_i[0] = 1;
    step(DEB + 2);
    chk("R4 gate0 on", gate_o, 2'b01);
    chk("R4 ctrl0 sampled", ctrl_on_o, 2'b01);
    chk("R8 busy after turn-on", busy_o, 1);
    chk("R2 status ch0", status_o[3:0], 4'hf);

    // R3: debounce restart on ch1 (ON low so no gate)
    cur_req = "R3";
    uv_ok_i[1] = 1; ov_ok_i[1] = 1; en_ni[1] = 0;
    step(5);
    uv_ok_i[1] = 0;
    step(1);
    uv_ok_i[1] = 1;
    step(DEB - 2);
    chk("R3 not yet ready", status_o[6], 0);
    step(4);
    chk("R3 ready", status_o[6:4], 3'b111);
    chk("R4 ctrl1 sampled low", ctrl_on_o[1], 0);
    step(SU + 2);

    // R8: host turn-on of ch1 waits while ch0's timer runs
    cur_req = "R8";
    en_ni[0] = 1; step(2); en_ni[0] = 0;
    step(DEB + 2);
    chk("R8 gate0 on again", gate_o[0], 1);
    hwrite(1, 1);
    step(3);
    chk("R8 ch1 waits while busy", gate_o[1], 0);
    chk("R5 ctrl1 set by host", ctrl_on_o[1], 1);
    step(SU);
    chk("R8 ch1 on after timer", gate_o[1], 1);
    chk("R8 busy for ch1 interval", busy_o, 1);

    // R6: host clear drops gate
    cur_req = "R6";
    hwrite(1, 0);
    step(1);
    chk("R6 gate1 off", gate_o[1], 0);
    chk("R6 ctrl1 cleared", ctrl_on_o[1], 0);
    step(SU + 2);

    // R10: ON rise bypasses busy timer
    cur_req = "R10";
    hwrite(0, 0);
    hwrite(0, 1);
    step(2);
    chk("R10 timer busy", busy_o, 1);
    on_i[1] = 1;
    step(2);
    chk("R10 ch1 on despite busy", gate_o[1], 1);
    chk("R5 ctrl1 set by ON edge", ctrl_on_o[1], 1);

    // R9: both waiting, ch0 wins
    cur_req = "R9";
    hwrite(1, 0);
    on_i[1] = 0;
    step(SU + 2);
    hwrite(0, 0);
    hwrite(0, 1);
    step(1);
    hwrite(0, 0);
    hwrite(1, 1);
    hwrite(0, 1);
    step(1);
    chk("R9 both waiting", gate_o, 2'b00);
    step(SU - 3);
    chk("R9 ch0 first", gate_o, 2'b01);
    step(SU + 2);
    chk("R9 ch1 next interval", gate_o, 2'b11);

    // R11: precondition loss
    cur_req = "R11";
    on_i[0] = 0;
    ov_ok_i[0] = 0;
    step(2);
    chk("R11 gate0 off", gate_o[0], 0);
    chk("R11 fault0 set", fault_o, 2'b01);
    chk("R11 not ready", status_o[2], 0);
    ov_ok_i[0] = 1;
    hwrite(1, 0);
    step(DEB + SU + 4);
    chk("R11 fault sticky", fault_o[0], 1);

    // R7: paired mode
    cur_req = "R7";
    indep_i = 0;
    step(2);
    hwrite(0, 1);
    step(3);
    chk("R7 one bit is not enough", gate_o, 2'b00);
    hwrite(1, 1);
    step(1);
    chk("R7 both on together", gate_o, 2'b11);
    chk("R7 timer started", busy_o, 1);
    en_ni[1] = 1;
    step(2);
    chk("R7 both off together", gate_o, 2'b00);
    chk("R11 fault1 set", fault_o, 2'b11);

    // R1: supply loss restarts window and clears state
    cur_req = "R1";
    supply_ok_i[1] = 0;
    step(2);
    chk("R1 window reopened", por_o, 1);
    chk("R1 ctrl and faults cleared", {ctrl_on_o, fault_o}, 4'b0000);
    supply_ok_i[1] = 1;
    step(POR + 2);
    chk("R1 window closed again", por_o, 0);
    step(2);
    report();
  end
endmodule